// File: doc/BRIEF.md
# Transmit FIFO Ready and Threshold Signalling

This block generates the transmit-side ready signalling for one serial channel that has a 64-entry transmit queue. It watches the number of free slots the queue reports, together with the host's write strobe to the transmit data register and its read strobe on the interrupt identification register. From these it produces three things: a data-register-empty status flag, a transmit-ready interrupt request, and a transmit-ready request line for a DMA controller. The queue storage and the bit serializer are outside the block. The block only consumes their free-slot count and an idle indication from the serializer.

Two host disciplines are supported. In interrupt-driven operation, the status flag and the interrupt follow a programmable free-space threshold. After each service, the host must write two characters before the interrupt can return, which gives a two-character hysteresis. In burst DMA operation, the request line rises once the free space passes the threshold and stays up until the queue is completely full. The DMA controller can therefore fill the queue in a single burst. With the queue disabled, the block behaves as a single-slot holding register.

Top module: `tx_ready_gen`

## Requirements
- R1: With the queue enabled, the status flag is 1 exactly when the free-slot count is strictly above the selected limit. Select code 0 gives 8, code 1 gives 16, code 2 gives 32 and code 3 gives 56 free slots. The flag follows the inputs one clock later.
- R2: With the queue disabled, the status flag is 1 exactly when the free-slot count equals 64 (nothing waiting).
- R3: While reset is high, the status flag, the DMA request line and the transmitter-empty flag read 1 and the interrupt output reads 0. The interrupt is left pending and armed.
- R4: The interrupt output equals the pending state gated by the interrupt enable, one clock later. A pending interrupt is kept while the enable is 0 and appears once the enable is set.
- R5: A transmit data write or an identification read clears the pending interrupt. A clear wins over a new set in the same cycle.
- R6: With the queue enabled, once the pending interrupt has been cleared, it can be raised again only after two data writes counted from the clearing event, and only while the R1 condition holds. A write that clears counts as the first of the two; an identification read restarts the count at zero.
- R7: With the queue disabled, there is no hysteresis. The interrupt becomes pending in any cycle with no clearing strobe where the R2 condition holds.
- R8: When the queue and the DMA mode select are both 1, the request line rises when the free-slot count is above the R1 limit. It then stays 1 until the free-slot count is 0, and after that returns only when the count is above the limit again.
- R9: Otherwise (mode select 0 or queue disabled), the request line is 1 exactly when the free-slot count equals 64.
- R10: The transmitter-empty flag is 1 exactly when the serializer reports idle and the free-slot count equals 64, one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_enable | input | 1 | Transmit queue enable |
| dma_burst | input | 1 | DMA mode select (1 = burst mode) |
| lim_sel | input | 2 | Free-space limit select code |
| txi_enable | input | 1 | Transmit interrupt enable |
| free_slots | input | 7 | Free slots in the transmit queue, 0 to 64 |
| data_wr | input | 1 | Host write strobe to the transmit data register |
| ident_rd | input | 1 | Host read strobe of the interrupt identification register |
| ser_idle | input | 1 | Serializer has no character in flight |
| hold_empty | output | 1 | Data-register-empty status flag |
| tx_irq | output | 1 | Transmit-ready interrupt request |
| dma_req | output | 1 | Transmit-ready request to a DMA controller |
| xmit_empty | output | 1 | Queue and serializer both empty |

## Verification
The hard collision is between a clearing strobe (a data write or an identification read) and the pending interrupt being raised again. This happens in the cycle where the write count reaches two while the free space is above the limit. The bench drives writes and reads with a random mix, sometimes both in one cycle, and keeps the free-slot count around each limit. A reference model then judges every cycle, and a clear must always win over a set. The DMA request line is checked in the same way when the count steps between zero and just above the limit while the mode select toggles.

// File: rtl/tx_rdy_pkg.sv
package tx_rdy_pkg;

  typedef enum logic [1:0] {
    LIM_EIGHTH       = 2'd0,
    LIM_QUARTER      = 2'd1,
    LIM_HALF         = 2'd2,
    LIM_SEVEN_EIGHTH = 2'd3
  } lim_code_e;

  // Free-space limit for a given code as a fraction of the queue depth.
  function automatic int unsigned space_limit(input logic [1:0] code,
                                              input int unsigned depth);
    case (lim_code_e'(code))
      LIM_EIGHTH:       return depth / 8;
      LIM_QUARTER:      return depth / 4;
      LIM_HALF:         return depth / 2;
      default:          return depth - depth / 8;
    endcase
  endfunction

endpackage

// File: rtl/tx_space_cmp.sv
module tx_space_cmp
  import tx_rdy_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter bit HAS_THRESH = 1'b1,
  parameter int CW         = $clog2(DEPTH + 1)
) (
  input  logic          q_enable,
  input  logic [1:0]    lim_sel,
  input  logic [CW-1:0] free_slots,
  output logic          above,
  output logic          all_free,
  output logic          none_free
);

  localparam logic [CW-1:0] FULL_FREE = CW'(DEPTH);

  logic [CW-1:0] limit;

  generate
    if (HAS_THRESH) begin : g_prog
      always_comb limit = CW'(space_limit(lim_sel, DEPTH));
    end else begin : g_fixed
      // Without a limit control only a fully drained queue counts.
      always_comb limit = FULL_FREE - CW'(1);
    end
  endgenerate

  always_comb begin
    all_free  = (free_slots == FULL_FREE);
    none_free = (free_slots == '0);
    above     = q_enable ? (free_slots > limit) : all_free;
  end

endmodule

// File: rtl/tx_irq_ctrl.sv
module tx_irq_ctrl #(
  parameter int NEED_WR = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic q_enable,
  input  logic above,
  input  logic data_wr,
  input  logic ident_rd,
  input  logic txi_enable,
  output logic pend_o,
  output logic irq_o
);

  localparam int WW = $clog2(NEED_WR + 1);
  localparam logic [WW-1:0] ARMED = WW'(NEED_WR);

  logic [WW-1:0] wr_cnt_q, wr_cnt_d;
  logic          pend_q, pend_d, irq_q;
  logic          armed, service;

  always_comb begin
    armed   = !q_enable || (wr_cnt_q == ARMED);
    service = data_wr || ident_rd;

    if (service)            pend_d = 1'b0;
    else if (above && armed) pend_d = 1'b1;
    else                    pend_d = pend_q;

    if (ident_rd)
      wr_cnt_d = data_wr ? WW'(1) : '0;
    else if (data_wr && pend_q)
      wr_cnt_d = WW'(1);
    else if (data_wr && wr_cnt_q != ARMED)
      wr_cnt_d = wr_cnt_q + WW'(1);
    else
      wr_cnt_d = wr_cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b1;
      wr_cnt_q <= ARMED;
      irq_q    <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      wr_cnt_q <= wr_cnt_d;
      irq_q    <= pend_d && txi_enable;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (data_wr || ident_rd) |=> !pend_q);

  a_r6_no_early_rearm: assert property (@(posedge clk) disable iff (rst)
    (q_enable && wr_cnt_q != ARMED && !pend_q) |=> !pend_q);

  a_r4_gated_off: assert property (@(posedge clk) disable iff (rst)
    !txi_enable |=> !irq_q);

endmodule

// File: rtl/tx_dma_req.sv
module tx_dma_req (
  input  logic clk,
  input  logic rst,
  input  logic burst_on,
  input  logic above,
  input  logic all_free,
  input  logic none_free,
  output logic req_o
);

  logic req_q, req_d;

  always_comb begin
    if (burst_on) req_d = req_q ? !none_free : above;
    else          req_d = all_free;
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b1;
    else     req_q <= req_d;
  end

  assign req_o = req_q;

  a_r8_hold_until_full: assert property (@(posedge clk) disable iff (rst)
    (burst_on && req_q && !none_free) |=> req_q);

  a_r8_drop_when_full: assert property (@(posedge clk) disable iff (rst)
    (burst_on && none_free) |=> !req_q);

endmodule

// File: rtl/tx_ready_gen.sv
module tx_ready_gen #(
  parameter int DEPTH      = 64,
  parameter bit HAS_THRESH = 1'b1,
  parameter int NEED_WR    = 2,
  parameter int CW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          q_enable,
  input  logic          dma_burst,
  input  logic [1:0]    lim_sel,
  input  logic          txi_enable,
  input  logic [CW-1:0] free_slots,
  input  logic          data_wr,
  input  logic          ident_rd,
  input  logic          ser_idle,
  output logic          hold_empty,
  output logic          tx_irq,
  output logic          dma_req,
  output logic          xmit_empty
);

  logic above, all_free, none_free, pend;
  logic hold_q, temt_q;

  tx_space_cmp #(.DEPTH(DEPTH), .HAS_THRESH(HAS_THRESH), .CW(CW)) u_cmp (
    .q_enable  (q_enable),
    .lim_sel   (lim_sel),
    .free_slots(free_slots),
    .above     (above),
    .all_free  (all_free),
    .none_free (none_free)
  );

  tx_irq_ctrl #(.NEED_WR(NEED_WR)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .q_enable  (q_enable),
    .above     (above),
    .data_wr   (data_wr),
    .ident_rd  (ident_rd),
    .txi_enable(txi_enable),
    .pend_o    (pend),
    .irq_o     (tx_irq)
  );

  tx_dma_req u_dma (
    .clk      (clk),
    .rst      (rst),
    .burst_on (q_enable && dma_burst),
    .above    (above),
    .all_free (all_free),
    .none_free(none_free),
    .req_o    (dma_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b1;
      temt_q <= 1'b1;
    end else begin
      hold_q <= above;
      temt_q <= ser_idle && all_free;
    end
  end

  assign hold_empty = hold_q;
  assign xmit_empty = temt_q;

  a_r1_low_space_clear: assert property (@(posedge clk) disable iff (rst)
    (q_enable && free_slots <= CW'(DEPTH / 8)) |=> !hold_empty);

  a_r10_busy_serializer: assert property (@(posedge clk) disable iff (rst)
    !ser_idle |=> !xmit_empty);

  a_r3_irq_needs_pending: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> pend || $past(data_wr || ident_rd));

endmodule

// File: tb/tx_ready_gen_bench.sv
`timescale 1ns/1ps
module tx_ready_gen_bench;

  localparam int DEPTH = 64;
  localparam int CW    = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          q_enable = 1'b1, dma_burst = 1'b0, txi_enable = 1'b0;
  logic [1:0]    lim_sel = 2'd0;
  logic [CW-1:0] free_slots = 7'd64;
  logic          data_wr = 1'b0, ident_rd = 1'b0, ser_idle = 1'b1;
  logic          hold_empty, tx_irq, dma_req, xmit_empty;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  logic m_hold, m_pend, m_irq, m_req, m_temt;
  int   m_cnt;

  always #2.5 clk = ~clk;

  tx_ready_gen u_tx_ready_gen (
    .clk(clk), .rst(rst), .q_enable(q_enable), .dma_burst(dma_burst),
    .lim_sel(lim_sel), .txi_enable(txi_enable), .free_slots(free_slots),
    .data_wr(data_wr), .ident_rd(ident_rd), .ser_idle(ser_idle),
    .hold_empty(hold_empty), .tx_irq(tx_irq), .dma_req(dma_req),
    .xmit_empty(xmit_empty)
  );

  function automatic int lim_of(input logic [1:0] c);
    case (c)
      2'd0: return 8;
      2'd1: return 16;
      2'd2: return 32;
      default: return 56;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
    end
  endtask

  task automatic model_edge();
    int  lim;
    bit  abv, armed, svc;
    lim = lim_of(lim_sel);
    if (rst) begin
      m_hold = 1; m_pend = 1; m_cnt = 2; m_irq = 0; m_req = 1; m_temt = 1;
      return;
    end
    abv   = q_enable ? (int'(free_slots) > lim) : (free_slots == 7'd64);
    armed = !q_enable || m_cnt == 2;
    svc   = data_wr || ident_rd;
    if (ident_rd)               m_cnt = data_wr ? 1 : 0;
    else if (data_wr && m_pend) m_cnt = 1;
    else if (data_wr && m_cnt < 2) m_cnt = m_cnt + 1;
    if (svc)              m_pend = 0;
    else if (abv && armed) m_pend = 1;
    m_irq  = m_pend && txi_enable;
    if (q_enable && dma_burst) m_req = m_req ? (free_slots != 0) : (int'(free_slots) > lim);
    else                       m_req = (free_slots == 7'd64);
    m_hold = abv;
    m_temt = ser_idle && free_slots == 7'd64;
  endtask

  task automatic step();
    @(posedge clk);
    cycles++;
    model_edge();
    #1;
    if (rst) begin
      check("R3 hold_empty", hold_empty, 1'b1);
      check("R3 tx_irq", tx_irq, 1'b0);
      check("R3 dma_req", dma_req, 1'b1);
      check("R3 xmit_empty", xmit_empty, 1'b1);
    end else begin
      check("R1 R2 hold_empty", hold_empty, m_hold);
      check("R4 R5 R6 R7 tx_irq", tx_irq, m_irq);
      check("R8 R9 dma_req", dma_req, m_req);
      check("R10 xmit_empty", xmit_empty, m_temt);
    end
  endtask

  task automatic drive(input logic wr, input logic rd, input logic [CW-1:0] fs);
    @(negedge clk);
    data_wr = wr; ident_rd = rd; free_slots = fs;
    step();
  endtask

  initial begin : watchdog
    while (!done && cycles < 150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd7151;
    void'($urandom(seed));
    // R3: reset state
    repeat (3) step();
    @(negedge clk); rst = 1'b0;
    // R4: pending held while disabled, then shown
    repeat (3) drive(0, 0, 7'd64);
    @(negedge clk); txi_enable = 1'b1;
    step();
    // R5/R6: write clears, one more write not enough, second arms
    lim_sel = 2'd3;
    drive(1, 0, 7'd60);
    drive(0, 0, 7'd60);
    drive(1, 0, 7'd60);
    drive(0, 0, 7'd60);
    drive(0, 1, 7'd60);
    drive(1, 1, 7'd60);
    drive(0, 0, 7'd60);
    drive(1, 0, 7'd60);
    drive(0, 0, 7'd60);
    // R8: DMA burst hysteresis around full
    dma_burst = 1'b1; lim_sel = 2'd1;
    drive(0, 0, 7'd17);
    drive(0, 0, 7'd5);
    drive(0, 0, 7'd0);
    drive(0, 0, 7'd10);
    drive(0, 0, 7'd16);
    drive(0, 0, 7'd17);
    // R2/R7/R9: queue disabled
    q_enable = 1'b0;
    drive(0, 1, 7'd64);
    drive(0, 0, 7'd63);
    drive(0, 0, 7'd64);
    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [CW-1:0] fs;
      r = $urandom;
      @(negedge clk);
      if (r[3:0] == 0) q_enable   = ~q_enable;
      if (r[7:4] == 0) dma_burst  = ~dma_burst;
      if (r[11:8] == 0) lim_sel   = 2'(r[13:12]);
      if (r[17:14] == 0) txi_enable = ~txi_enable;
      ser_idle = r[18] | r[19];
      data_wr  = (r[22:20] == 0);
      ident_rd = (r[25:23] == 0);
      case (r[28:26])
        3'd0: fs = 7'd0;
        3'd1: fs = 7'd64;
        3'd2: fs = 7'(lim_of(lim_sel));
        3'd3: fs = 7'(lim_of(lim_sel) + 1);
        default: fs = 7'($urandom_range(0, 64));
      endcase
      free_slots = fs;
      step();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule